// File: doc/BRIEF.md
# One-Time-Programmable Trim Register Bank

This block keeps the calibration trims of a sensor front end: two offset fields, two gain fields, a temperature-coefficient code, a clamp selector, an output-polarity bit and a device lock. Every bit is the OR of a volatile trial bit and an emulated fuse. Trial bits let a tester step a value and watch the result. Fuses make a chosen bit permanent, one bit per power cycle. Once the lock fuse is set, the bank is frozen.

The tester picks a register with `reg_sel`. `sel_stb` clears the trial bits of that register. `inc_stb` counts its trial value up by one. `blow_stb` turns the single trial bit that is not yet fused into a fuse. `por_n` models a power cycle: it clears the trial bits and the blow permission, and the fuses survive it. `fuse_init_n` is a test-only input that clears the fuse flops.

Top module: `otp_trim_bank`

## Requirements
- R1: After `fuse_init_n` and `por_n` have both been asserted and then released, every trim output reads 0, and `locked` and `blow_err` are 0.
- R2: Asserting `por_n` clears all trial bits, the blow permission and `blow_err`. Fused bits keep reading 1 afterwards.
- R3: Register indices are 0 offset coarse (2 bits), 1 offset fine (9), 2 gain coarse (2), 3 gain fine (8), 4 temperature code (5), 5 clamp (2), 6 polarity (1) and 7 lock (1). On `sel_stb`, the trial bits of the indexed register become 0 and all other registers keep their value. Each output reads trial OR fuse.
- R4: On `inc_stb`, the trial value of the indexed register becomes its previous trial value plus 1, modulo 2^width.
- R5: For indices 0, 2 and 5, the trial value steps 0, 1, 2, 0, so 3 is never a trial value.
- R6: On `blow_stb`, the candidate is the selected register's trial bits AND NOT its fuses. If the candidate has exactly one bit set, that fuse becomes 1 at the next edge and is ORed into the existing fuses. Fuses are never cleared except by `fuse_init_n`.
- R7: A `blow_stb` whose candidate has zero set bits, or more than one, changes no fuse and sets `blow_err`. `blow_err` stays set until the next `por_n`.
- R8: After one successful blow, every further `blow_stb` is rejected with `blow_err` until the next `por_n`.
- R9: When strobes coincide, `sel_stb` takes precedence over `blow_stb`, and `blow_stb` takes precedence over `inc_stb`. The losing strobes have no effect.
- R10: Once the lock fuse (index 7) is blown, `locked` reads 1 and every output shows its fuses only. Select and increment strobes are then ignored, and every blow is rejected with `blow_err`.
- R11: `fuse_init_n` clears every fuse, including the lock fuse, without needing `por_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low; clears the volatile state |
| fuse_init_n | input | 1 | Test-only fuse clear, active low |
| reg_sel | input | 3 | Register index |
| sel_stb | input | 1 | Select strobe; clears the trial bits of the indexed register |
| inc_stb | input | 1 | Increment strobe for the trial value |
| blow_stb | input | 1 | Fuse blow strobe |
| ofs_coarse | output | OFS_C_W | Offset coarse code |
| ofs_fine | output | OFS_F_W | Offset fine code |
| gain_coarse | output | GAIN_C_W | Gain coarse code |
| gain_fine | output | GAIN_F_W | Gain fine code |
| tc_code | output | TC_W | Temperature-coefficient code |
| clamp_code | output | CLAMP_W | Clamp selector |
| polarity | output | POL_W | Output polarity |
| locked | output | 1 | Lock fuse state |
| blow_err | output | 1 | Sticky flag for a rejected blow |

## Verification
A blow and an increment can fall in the same cycle. The bench raises both strobes together on a register whose trial value holds one unfused bit. It judges that the blow used the value from before the increment and that the increment was dropped: the output stays at 1 rather than moving to 2 or 3, and it still reads 1 after a power cycle. The bench also provokes select against increment and select against blow in one cycle, and checks that only the clear takes effect and that no error is raised.

// File: rtl/otp_trim_pkg.sv
package otp_trim_pkg;

    localparam int unsigned NREG  = 8;
    localparam int unsigned IDX_W = 3;

    typedef enum logic [IDX_W-1:0] {
        TR_OFS_C  = 3'd0,
        TR_OFS_F  = 3'd1,
        TR_GAIN_C = 3'd2,
        TR_GAIN_F = 3'd3,
        TR_TC     = 3'd4,
        TR_CLAMP  = 3'd5,
        TR_POL    = 3'd6,
        TR_LOCK   = 3'd7
    } trim_idx_e;

    // Registers whose trial counter skips code 3.
    function automatic bit is_short_wrap(int unsigned k);
        return (k == int'(TR_OFS_C)) || (k == int'(TR_GAIN_C)) || (k == int'(TR_CLAMP));
    endfunction

endpackage

// File: rtl/otp_fuse_bank.sv
module otp_fuse_bank #(
    parameter int unsigned NBITS = 30
) (
    input  logic             clk,
    input  logic             init_n,
    input  logic             wr_en,
    input  logic [NBITS-1:0] wr_bits,
    output logic [NBITS-1:0] fuse_q
);

    typedef struct packed {
        logic [NBITS-1:0] fuse;
    } fb_t;

    fb_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.fuse = st_q.fuse | wr_bits;
        end
    end

    always_ff @(posedge clk or negedge init_n) begin
        if (!init_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign fuse_q = st_q.fuse;

    AST_FUSE_STICKY: assert property (@(posedge clk) disable iff (!init_n)
        ((fuse_q & $past(fuse_q)) == $past(fuse_q))); // R6

    AST_ONE_FUSE_PER_EDGE: assert property (@(posedge clk) disable iff (!init_n)
        ($countones(fuse_q ^ $past(fuse_q)) <= 1)); // R6

endmodule

// File: rtl/otp_trim_field.sv
module otp_trim_field #(
    parameter int unsigned W     = 2,
    parameter bit          WRAP3 = 1'b0
) (
    input  logic         clk,
    input  logic         por_n,
    input  logic         clr,
    input  logic         inc,
    input  logic         frz,
    input  logic [W-1:0] fuse,
    output logic [W-1:0] val,
    output logic [W-1:0] cand
);

    localparam bit SKIP3 = WRAP3 && (W == 2);

    typedef struct packed {
        logic [W-1:0] vol;
    } fld_t;

    fld_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!frz) begin
            if (clr) begin
                st_d.vol = '0;
            end else if (inc) begin
                if (SKIP3 && (st_q.vol == W'(2))) begin
                    st_d.vol = '0;
                end else begin
                    st_d.vol = st_q.vol + W'(1);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign val  = frz ? fuse : (st_q.vol | fuse);
    assign cand = st_q.vol & ~fuse;

    AST_SELECT_CLEARS: assert property (@(posedge clk) disable iff (!por_n)
        (clr && !frz) |=> (st_q.vol == '0)); // R3

    generate
        if (SKIP3) begin : g_skip3
            AST_NO_CODE3: assert property (@(posedge clk) disable iff (!por_n)
                (st_q.vol != W'(3))); // R5
        end
    endgenerate

endmodule

// File: rtl/otp_trim_bank.sv
module otp_trim_bank
    import otp_trim_pkg::*;
#(
    parameter int unsigned OFS_C_W  = 2,
    parameter int unsigned OFS_F_W  = 9,
    parameter int unsigned GAIN_C_W = 2,
    parameter int unsigned GAIN_F_W = 8,
    parameter int unsigned TC_W     = 5,
    parameter int unsigned CLAMP_W  = 2,
    parameter int unsigned POL_W    = 1
) (
    input  logic                clk,
    input  logic                por_n,
    input  logic                fuse_init_n,
    input  logic [IDX_W-1:0]    reg_sel,
    input  logic                sel_stb,
    input  logic                inc_stb,
    input  logic                blow_stb,
    output logic [OFS_C_W-1:0]  ofs_coarse,
    output logic [OFS_F_W-1:0]  ofs_fine,
    output logic [GAIN_C_W-1:0] gain_coarse,
    output logic [GAIN_F_W-1:0] gain_fine,
    output logic [TC_W-1:0]     tc_code,
    output logic [CLAMP_W-1:0]  clamp_code,
    output logic [POL_W-1:0]    polarity,
    output logic                locked,
    output logic                blow_err
);

    localparam int unsigned FW [NREG] = '{OFS_C_W, OFS_F_W, GAIN_C_W, GAIN_F_W,
                                          TC_W, CLAMP_W, POL_W, 1};

    function automatic int unsigned lsb_of(int unsigned k);
        int unsigned s;
        s = 0;
        for (int unsigned j = 0; j < k; j++) begin
            s += FW[j];
        end
        return s;
    endfunction

    localparam int unsigned TOTAL    = lsb_of(NREG);
    localparam int unsigned LOCK_BIT = lsb_of(NREG - 1);

    typedef struct packed {
        logic armed;
        logic err;
    } ctl_t;

    ctl_t             ctl_d, ctl_q;
    logic [TOTAL-1:0] fuse_q;
    logic [TOTAL-1:0] val_flat;
    logic [TOTAL-1:0] cand_flat;
    logic [TOTAL-1:0] sel_mask;
    logic [TOTAL-1:0] cand_sel;
    logic             frz;
    logic             blow_act;
    logic             blow_ok;

    assign frz      = fuse_q[LOCK_BIT];
    assign blow_act = blow_stb && !sel_stb;
    assign cand_sel = cand_flat & sel_mask;

    generate
        for (genvar g = 0; g < NREG; g++) begin : g_fld
            localparam int unsigned L = lsb_of(g);
            localparam int unsigned W = FW[g];
            logic hit;
            assign hit = (reg_sel == IDX_W'(g));
            assign sel_mask[L +: W] = {W{hit}};

            otp_trim_field #(
                .W     (W),
                .WRAP3 (is_short_wrap(g))
            ) i_field (
                .clk   (clk),
                .por_n (por_n),
                .clr   (hit && sel_stb),
                .inc   (hit && inc_stb && !sel_stb && !blow_stb),
                .frz   (frz),
                .fuse  (fuse_q[L +: W]),
                .val   (val_flat[L +: W]),
                .cand  (cand_flat[L +: W])
            );
        end
    endgenerate

    always_comb begin
        ctl_d   = ctl_q;
        blow_ok = 1'b0;
        if (blow_act) begin
            if (ctl_q.armed && !frz && ($countones(cand_sel) == 1)) begin
                blow_ok     = 1'b1;
                ctl_d.armed = 1'b0;
            end else begin
                ctl_d.err = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            ctl_q <= '{armed: 1'b1, err: 1'b0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    otp_fuse_bank #(
        .NBITS (TOTAL)
    ) i_fuses (
        .clk     (clk),
        .init_n  (fuse_init_n),
        .wr_en   (blow_ok),
        .wr_bits (cand_sel),
        .fuse_q  (fuse_q)
    );

    assign ofs_coarse  = val_flat[lsb_of(0) +: OFS_C_W];
    assign ofs_fine    = val_flat[lsb_of(1) +: OFS_F_W];
    assign gain_coarse = val_flat[lsb_of(2) +: GAIN_C_W];
    assign gain_fine   = val_flat[lsb_of(3) +: GAIN_F_W];
    assign tc_code     = val_flat[lsb_of(4) +: TC_W];
    assign clamp_code  = val_flat[lsb_of(5) +: CLAMP_W];
    assign polarity    = val_flat[lsb_of(6) +: POL_W];
    assign locked      = frz;
    assign blow_err    = ctl_q.err;

    AST_BAD_BLOW_FLAGS: assert property (@(posedge clk) disable iff (!por_n || !fuse_init_n)
        (blow_act && ($countones(cand_sel) != 1)) |=> blow_err); // R7

    AST_LOCK_FREEZES_FUSES: assert property (@(posedge clk) disable iff (!fuse_init_n)
        locked |=> $stable(fuse_q)); // R10

    AST_LOCK_READS_FUSE: assert property (@(posedge clk) disable iff (!fuse_init_n)
        locked |-> val_flat[LOCK_BIT]); // R10

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!por_n)
        blow_err |=> blow_err); // R7

endmodule

// File: tb/test_otp_trim_bank.sv
module test_otp_trim_bank;
    import otp_trim_pkg::*;

    logic       clk = 1'b0;
    logic       por_n = 1'b0;
    logic       fuse_init_n = 1'b0;
    logic [2:0] reg_sel = '0;
    logic       sel_stb = 1'b0;
    logic       inc_stb = 1'b0;
    logic       blow_stb = 1'b0;
    logic [1:0] ofs_coarse;
    logic [8:0] ofs_fine;
    logic [1:0] gain_coarse;
    logic [7:0] gain_fine;
    logic [4:0] tc_code;
    logic [1:0] clamp_code;
    logic [0:0] polarity;
    logic       locked;
    logic       blow_err;

    always #10 clk = ~clk;

    otp_trim_bank i_otp_trim_bank (
        .clk(clk), .por_n(por_n), .fuse_init_n(fuse_init_n), .reg_sel(reg_sel),
        .sel_stb(sel_stb), .inc_stb(inc_stb), .blow_stb(blow_stb),
        .ofs_coarse(ofs_coarse), .ofs_fine(ofs_fine), .gain_coarse(gain_coarse),
        .gain_fine(gain_fine), .tc_code(tc_code), .clamp_code(clamp_code),
        .polarity(polarity), .locked(locked), .blow_err(blow_err)
    );

    localparam int BW [8] = '{2, 9, 2, 8, 5, 2, 1, 1};

    int  n_cmp = 0;
    int  n_bad = 0;
    int  ev [8];
    int  ef [8];
    bit  armed;
    bit  err;
    bit  done = 1'b0;

    function automatic int next_try(int k, int v);
        if ((k == 0 || k == 2 || k == 5) && v == 2) return 0;
        return (v + 1) % (1 << BW[k]);
    endfunction

    function automatic int shown(int k);
        if (ef[7] != 0) return ef[k];
        return ev[k] | ef[k];
    endfunction

    function automatic int out_of(int k);
        case (k)
            0: return int'(ofs_coarse);
            1: return int'(ofs_fine);
            2: return int'(gain_coarse);
            3: return int'(gain_fine);
            4: return int'(tc_code);
            5: return int'(clamp_code);
            default: return int'(polarity);
        endcase
    endfunction

    task automatic chk(string req, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic check_all(string req);
        for (int k = 0; k < 7; k++) chk(req, out_of(k), shown(k));
        chk(req, int'(locked), ef[7]);
        chk(req, int'(blow_err), int'(err));
    endtask

    task automatic pulse(int idx, bit s, bit i, bit b);
        bit lk;
        int c;
        lk = (ef[7] != 0);
        if (s) begin
            if (!lk) ev[idx] = 0;
        end else if (b) begin
            c = ev[idx] & ~ef[idx];
            if (lk || !armed || $countones(c) != 1) err = 1'b1;
            else begin
                ef[idx] |= c;
                armed = 1'b0;
            end
        end else if (i) begin
            if (!lk) ev[idx] = next_try(idx, ev[idx]);
        end
        @(negedge clk);
        reg_sel = 3'(idx); sel_stb = s; inc_stb = i; blow_stb = b;
        @(negedge clk);
        sel_stb = 1'b0; inc_stb = 1'b0; blow_stb = 1'b0;
    endtask

    task automatic power_up();
        @(negedge clk);
        por_n = 1'b0;
        @(negedge clk);
        por_n = 1'b1;
        for (int k = 0; k < 8; k++) ev[k] = 0;
        armed = 1'b1;
        err = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        for (int k = 0; k < 8; k++) begin ev[k] = 0; ef[k] = 0; end
        armed = 1'b1;
        err = 1'b0;
        repeat (3) @(negedge clk);
        fuse_init_n = 1'b1;
        por_n = 1'b1;
        @(negedge clk);
        check_all("R1");

        // R4 R5: sweep each register past its wrap point
        for (int k = 0; k < 7; k++) begin
            pulse(k, 1'b1, 1'b0, 1'b0);
            check_all("R3");
            for (int n = 0; n < (1 << BW[k]) + 2; n++) begin
                pulse(k, 1'b0, 1'b1, 1'b0);
                check_all((k == 0 || k == 2 || k == 5) ? "R5" : "R4");
            end
        end
        pulse(3, 1'b1, 1'b0, 1'b0);
        check_all("R3");
        power_up();
        check_all("R2");

        // R6: blow a single bit of the clamp, then OR in another bit
        pulse(5, 1'b1, 1'b0, 1'b0);
        pulse(5, 1'b0, 1'b1, 1'b0);
        pulse(5, 1'b0, 1'b1, 1'b0);
        check_all("R4");
        pulse(5, 1'b0, 1'b0, 1'b1);
        check_all("R6");
        pulse(5, 1'b1, 1'b0, 1'b0);
        pulse(5, 1'b0, 1'b1, 1'b0);
        pulse(5, 1'b0, 1'b0, 1'b1);
        check_all("R8");
        power_up();
        check_all("R2");
        pulse(5, 1'b1, 1'b0, 1'b0);
        check_all("R3");
        pulse(5, 1'b0, 1'b1, 1'b0);
        pulse(5, 1'b0, 1'b0, 1'b1);
        check_all("R6");
        power_up();
        check_all("R6");

        // R7: candidates with two bits and with none
        pulse(3, 1'b0, 1'b1, 1'b0);
        pulse(3, 1'b0, 1'b1, 1'b0);
        pulse(3, 1'b0, 1'b1, 1'b0);
        pulse(3, 1'b0, 1'b0, 1'b1);
        check_all("R7");
        power_up();
        check_all("R7");
        pulse(4, 1'b0, 1'b0, 1'b1);
        check_all("R7");
        power_up();
        pulse(5, 1'b0, 1'b1, 1'b0);
        pulse(5, 1'b0, 1'b0, 1'b1);
        check_all("R7");

        // R9: coinciding strobes
        power_up();
        pulse(1, 1'b0, 1'b1, 1'b0);
        pulse(1, 1'b0, 1'b1, 1'b1);
        check_all("R9");
        pulse(1, 1'b0, 1'b1, 1'b0);
        check_all("R9");
        pulse(1, 1'b1, 1'b1, 1'b0);
        check_all("R9");
        pulse(2, 1'b0, 1'b1, 1'b0);
        pulse(2, 1'b1, 1'b0, 1'b1);
        check_all("R9");
        power_up();
        check_all("R9");

        // R10: lock
        pulse(2, 1'b0, 1'b1, 1'b0);
        pulse(7, 1'b0, 1'b1, 1'b0);
        check_all("R10");
        pulse(7, 1'b0, 1'b0, 1'b1);
        check_all("R10");
        pulse(1, 1'b0, 1'b1, 1'b0);
        check_all("R10");
        pulse(5, 1'b1, 1'b0, 1'b0);
        check_all("R10");
        power_up();
        pulse(6, 1'b0, 1'b1, 1'b0);
        pulse(6, 1'b0, 1'b0, 1'b1);
        check_all("R10");

        // R11: test-only fuse clear without a power cycle
        @(negedge clk);
        fuse_init_n = 1'b0;
        @(negedge clk);
        fuse_init_n = 1'b1;
        for (int k = 0; k < 8; k++) ef[k] = 0;
        check_all("R11");
        power_up();
        check_all("R11");

        finish_run();
    end

endmodule